// File: doc/BRIEF.md
# System Coprocessor Register Bank

This block holds the privileged control registers of a small 32-bit MIPS-like core: a thread pointer, the bad-address register, the cycle counter and its compare value, status, cause, the exception return address, the exception base and a configuration word. The core reads and writes them by register number and select. Each register keeps only the bits that its writable mask allows, and it comes out of reset at its own initial value.

The block also does the bookkeeping for taking an exception. It records the cause code and whether the faulting instruction sat in a branch delay slot. It saves the return address and raises the exception-level flag. Separately, it copies six hardware interrupt lines into the cause pending field every cycle. From those lines it raises a core interrupt request, gated by the status mask and by the exception and error level flags. It also presents the handler address, which is the exception base plus a fixed offset.

The core's trap logic uses the request and the vector output. A dedicated control input lets the pipeline set or clear the exception level directly, for example on an exception return.

Top module: `sysctl_cp_regs`

## Requirements
- R1: After reset, the register at (15,1) reads 0x80000000, every other register reads 0, `vec_addr` is 0x80000180 and `irq_req` is 0.
- R2: A write to (4,2) or (14,0) replaces all 32 bits. It takes effect at the next rising clock edge, and until then reads return the old value combinationally.
- R3: A write to (15,1) keeps bits 31:2 from `wr_data` and leaves bits 1:0 at 0. `vec_addr` always equals that register plus 0x180, modulo 2^32.
- R4: A write to (12,0) changes only bit 0 (interrupt enable) and bits 15:8 (interrupt mask). Writing all ones reads back 0x0000FF01.
- R5: Writes to (8,0), (9,0), (11,0), (13,0) and (16,0) have no effect. Any other (num,sel) pair, such as (15,0) or (12,1), reads 0, and a write to it changes no register.
- R6: Cause bits 15:8 equal {`hw_irq`[5:0], 2'b00} as sampled at the previous rising edge, so `hw_irq`[0] appears at bit 10 and `hw_irq`[1] appears at bit 11.
- R7: `irq_req` is 1 exactly when cause bits 15:8 ANDed with status bits 15:8 are nonzero, status bit 1 (EXL) is 0 and status bit 2 (ERL) is 0.
- R8: When `exc_take` is high, the next edge does all of the following: it writes `exc_code` into cause bits 6:2 and `exc_in_slot` into cause bit 31; it loads the EPC register (14,0) with `exc_pc`, or with `exc_pc` minus 4 when `exc_in_slot` is set; and it sets status bit 1. This takes precedence over a software write to EPC in the same cycle.
- R9: When `exl_load` is high, status bit 1 takes `exl_value` at the next edge, unless `exc_take` is also high, in which case the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_num | input | 5 | Read register number |
| rd_sel | input | 3 | Read select |
| rd_data | output | 32 | Combinational read data |
| wr_en | input | 1 | Software write strobe |
| wr_num | input | 5 | Write register number |
| wr_sel | input | 3 | Write select |
| wr_data | input | 32 | Write data |
| hw_irq | input | 6 | Hardware interrupt lines; line 1 is serial receive, line 0 is serial transmit |
| exc_take | input | 1 | Record an exception this cycle |
| exc_code | input | 5 | Exception cause code |
| exc_in_slot | input | 1 | Faulting instruction was in a delay slot |
| exc_pc | input | 32 | PC of the faulting instruction |
| exl_load | input | 1 | Load the exception-level flag directly |
| exl_value | input | 1 | Value for the exception-level flag |
| irq_req | output | 1 | Core interrupt request |
| vec_addr | output | 32 | Exception handler address |

## Verification
The bench writes all ones to every register. This catches a design that applies the wrong mask: status would read back more than 0x0000FF01, the base would keep its low bits, or a read-only register would change. It also writes to decoded-but-unsupported pairs, where a sloppy decoder that ignores the select would corrupt the exception base or status. The bench checks the interrupt request against a mask that excludes the asserted line, which exposes a design that ORs the lines without masking. It also checks the request while the exception level is set. It takes delay-slot exceptions, where a design that forgets the minus 4 or the cause bit 31 records the wrong return address. It also drives an exception together with a software EPC write and with a conflicting exception-level load, so a wrong priority shows up in EPC or in status bit 1.

// File: rtl/sysctl_cp_regs.sv
module sysctl_cp_regs #(
  parameter logic [31:0] EBASE_RESET = 32'h8000_0000,
  parameter logic [31:0] VEC_OFFSET  = 32'h0000_0180
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  rd_num,
  input  logic [2:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        wr_en,
  input  logic [4:0]  wr_num,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [5:0]  hw_irq,
  input  logic        exc_take,
  input  logic [4:0]  exc_code,
  input  logic        exc_in_slot,
  input  logic [31:0] exc_pc,
  input  logic        exl_load,
  input  logic        exl_value,
  output logic        irq_req,
  output logic [31:0] vec_addr
);
  localparam int NREG = 9;
  localparam logic [3:0] I_UL = 4'd0, I_BV = 4'd1, I_CNT = 4'd2, I_CMP = 4'd3,
                         I_ST = 4'd4, I_CA = 4'd5, I_EPC = 4'd6, I_EB = 4'd7,
                         I_CFG = 4'd8, I_NONE = 4'd15;

  logic [31:0] r [NREG];

  function automatic logic [3:0] map_idx(input logic [4:0] n, input logic [2:0] s);
    case ({n, s})
      {5'd4,  3'd2}: map_idx = I_UL;
      {5'd8,  3'd0}: map_idx = I_BV;
      {5'd9,  3'd0}: map_idx = I_CNT;
      {5'd11, 3'd0}: map_idx = I_CMP;
      {5'd12, 3'd0}: map_idx = I_ST;
      {5'd13, 3'd0}: map_idx = I_CA;
      {5'd14, 3'd0}: map_idx = I_EPC;
      {5'd15, 3'd1}: map_idx = I_EB;
      {5'd16, 3'd0}: map_idx = I_CFG;
      default:       map_idx = I_NONE;
    endcase
  endfunction

  function automatic logic [31:0] wmask(input logic [3:0] i);
    case (i)
      I_UL, I_EPC: wmask = 32'hFFFF_FFFF;
      I_EB:        wmask = 32'hFFFF_FFFC;
      I_ST:        wmask = 32'h0000_FF01;
      default:     wmask = 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] rinit(input logic [3:0] i);
    rinit = (i == I_EB) ? EBASE_RESET : 32'h0;
  endfunction

  logic [3:0] widx, ridx;
  assign widx = map_idx(wr_num, wr_sel);
  assign ridx = map_idx(rd_num, rd_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) r[i] <= rinit(4'(i));
    end else begin
      for (int i = 0; i < NREG; i++)
        if (wr_en && widx == 4'(i))
          r[i] <= (r[i] & ~wmask(4'(i))) | (wr_data & wmask(4'(i)));
      r[I_CA][15:8] <= {hw_irq, 2'b00};
      if (exl_load) r[I_ST][1] <= exl_value;
      if (exc_take) begin
        r[I_CA][31]  <= exc_in_slot;
        r[I_CA][6:2] <= exc_code;
        r[I_EPC]     <= exc_in_slot ? exc_pc - 32'd4 : exc_pc;
        r[I_ST][1]   <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = 32'h0;
    for (int i = 0; i < NREG; i++)
      if (ridx == 4'(i)) rd_data = r[i];
  end

  logic [7:0] pend;
  assign pend     = r[I_CA][15:8] & r[I_ST][15:8];
  assign irq_req  = (|pend) && (|r[I_ST][15:8]) && !r[I_ST][1] && !r[I_ST][2];
  assign vec_addr = r[I_EB] + VEC_OFFSET;

  assert_exc_sets_exl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> r[I_ST][1]);
  assert_slot_epc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && exc_in_slot) |=> r[I_EPC] == $past(exc_pc) - 32'd4);
  assert_exl_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exl_load && !exc_take) |=> r[I_ST][1] == $past(exl_value));
  assert_ip_mirror_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> r[I_CA][15:8] == {$past(hw_irq), 2'b00});
  assert_count_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(r[I_CNT]) && $stable(r[I_CFG]) && $stable(r[I_BV]));
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !(r[I_ST][1] || r[I_ST][2]));
endmodule

// File: tb/sysctl_cp_regs_tb_top.sv
module sysctl_cp_regs_tb_top;
  logic clk = 0, rst_n = 0;
  logic [4:0] rd_num = 0, wr_num = 0;
  logic [2:0] rd_sel = 0, wr_sel = 0;
  logic [31:0] rd_data, wr_data = 0, exc_pc = 0, vec_addr;
  logic wr_en = 0, exc_take = 0, exc_in_slot = 0, exl_load = 0, exl_value = 0, irq_req;
  logic [5:0] hw_irq = 0;
  logic [4:0] exc_code = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sysctl_cp_regs dut_i (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [4:0] n, input logic [2:0] s, output logic [31:0] v);
    rd_num = n; rd_sel = s; #1; v = rd_data;
  endtask

  task automatic wr(input logic [4:0] n, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_num = n; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; hw_irq = 0;
    repeat (2) @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(15, 1, v); chk("R1 ebase", v, 32'h8000_0000);
    rd(4, 2, v);  chk("R1 userlocal", v, 0);
    rd(12, 0, v); chk("R1 status", v, 0);
    rd(13, 0, v); chk("R1 cause", v, 0);
    rd(14, 0, v); chk("R1 epc", v, 0);
    chk("R1 vec", vec_addr, 32'h8000_0180);
    chk("R1 irq", {31'b0, irq_req}, 0);
  endtask

  task automatic t_full_write();
    logic [31:0] v;
    do_reset();
    @(negedge clk); wr_en = 1; wr_num = 4; wr_sel = 2; wr_data = 32'hDEAD_BEEF;
    rd(4, 2, v); chk("R2 old value before edge", v, 0);
    @(negedge clk); wr_en = 0;
    rd(4, 2, v); chk("R2 userlocal", v, 32'hDEAD_BEEF);
    wr(14, 0, 32'h1234_5678);
    rd(14, 0, v); chk("R2 epc", v, 32'h1234_5678);
  endtask

  task automatic t_ebase();
    logic [31:0] v;
    do_reset();
    wr(15, 1, 32'hFFFF_FFFF);
    rd(15, 1, v); chk("R3 ebase ones", v, 32'hFFFF_FFFC);
    chk("R3 vec wrap", vec_addr, 32'h0000_017C);
    wr(15, 1, 32'h9000_0003);
    rd(15, 1, v); chk("R3 ebase", v, 32'h9000_0000);
    chk("R3 vec", vec_addr, 32'h9000_0180);
  endtask

  task automatic t_status();
    logic [31:0] v;
    do_reset();
    wr(12, 0, 32'hFFFF_FFFF);
    rd(12, 0, v); chk("R4 status ones", v, 32'h0000_FF01);
    wr(12, 0, 32'h0);
    rd(12, 0, v); chk("R4 status zero", v, 0);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    do_reset();
    wr(8, 0, '1);  rd(8, 0, v);  chk("R5 badvaddr", v, 0);
    wr(9, 0, '1);  rd(9, 0, v);  chk("R5 count", v, 0);
    wr(11, 0, '1); rd(11, 0, v); chk("R5 compare", v, 0);
    wr(13, 0, '1); rd(13, 0, v); chk("R5 cause", v, 0);
    wr(16, 0, '1); rd(16, 0, v); chk("R5 config", v, 0);
    wr(15, 0, '1); rd(15, 0, v); chk("R5 unsupported reads 0", v, 0);
    rd(15, 1, v); chk("R5 ebase untouched", v, 32'h8000_0000);
    wr(12, 1, '1); rd(12, 0, v); chk("R5 status untouched", v, 0);
  endtask

  task automatic t_cause_ip();
    logic [31:0] v;
    do_reset();
    @(negedge clk); hw_irq = 6'b000010;
    @(negedge clk); rd(13, 0, v); chk("R6 rx line", v, 32'h0000_0800);
    hw_irq = 6'b000001;
    @(negedge clk); rd(13, 0, v); chk("R6 tx line", v, 32'h0000_0400);
    hw_irq = 6'b100000;
    @(negedge clk); rd(13, 0, v); chk("R6 top line", v, 32'h0000_8000);
    hw_irq = 0;
  endtask

  task automatic t_irq();
    do_reset();
    wr(12, 0, 32'h0000_0800);
    @(negedge clk); hw_irq = 6'b000001;
    @(negedge clk); #1; chk("R7 masked line", {31'b0, irq_req}, 0);
    hw_irq = 6'b000010;
    @(negedge clk); #1; chk("R7 enabled line", {31'b0, irq_req}, 1);
    exl_load = 1; exl_value = 1;
    @(negedge clk); exl_load = 0; #1; chk("R7 blocked by exl", {31'b0, irq_req}, 0);
    exl_load = 1; exl_value = 0;
    @(negedge clk); exl_load = 0; #1; chk("R7 exl cleared", {31'b0, irq_req}, 1);
    wr(12, 0, 32'h0); #1; chk("R7 mask zero", {31'b0, irq_req}, 0);
    hw_irq = 0;
  endtask

  task automatic t_exc();
    logic [31:0] v;
    do_reset();
    @(negedge clk); exc_take = 1; exc_code = 5'd4; exc_in_slot = 0; exc_pc = 32'h0040_0010;
    @(negedge clk); exc_take = 0;
    rd(14, 0, v); chk("R8 epc", v, 32'h0040_0010);
    rd(13, 0, v); chk("R8 cause", v, 32'h0000_0010);
    rd(12, 0, v); chk("R8 exl set", v, 32'h0000_0002);
    @(negedge clk); exc_take = 1; exc_code = 5'd12; exc_in_slot = 1; exc_pc = 32'h0040_0020;
    wr_en = 1; wr_num = 14; wr_sel = 0; wr_data = 32'hAAAA_AAAA;
    @(negedge clk); exc_take = 0; wr_en = 0; exc_in_slot = 0;
    rd(14, 0, v); chk("R8 slot epc beats sw write", v, 32'h0040_001C);
    rd(13, 0, v); chk("R8 slot cause", v, 32'h8000_0030);
  endtask

  task automatic t_exl();
    logic [31:0] v;
    do_reset();
    @(negedge clk); exl_load = 1; exl_value = 1;
    @(negedge clk); exl_load = 0;
    rd(12, 0, v); chk("R9 exl set", v, 32'h2);
    @(negedge clk); exl_load = 1; exl_value = 0;
    @(negedge clk); exl_load = 0;
    rd(12, 0, v); chk("R9 exl clear", v, 32'h0);
    @(negedge clk); exl_load = 1; exl_value = 0; exc_take = 1; exc_pc = 32'h100;
    @(negedge clk); exl_load = 0; exc_take = 0;
    rd(12, 0, v); chk("R9 exception wins", v, 32'h2);
  endtask

  initial begin
    t_reset(); t_full_write(); t_ebase(); t_status(); t_readonly();
    t_cause_ip(); t_irq(); t_exc(); t_exl();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule